// File: doc/BRIEF.md
# DisplayPort link training controller

This block brings up a DisplayPort main link of one, two or four lanes. From the sink's advertised maximum rate and lane count, the encoder's own limits and the data rate the stream needs, it picks a link configuration. It writes that configuration to the sink and then runs two training phases: clock recovery with pattern 1 and channel equalisation with pattern 2. It reaches the sink only through an abstract AUX request port. Each request carries a direction, a 20-bit register address, a byte count of up to six and up to four write bytes. The transport answers with a one-cycle acknowledge, a success flag and up to six read bytes.

In each training iteration the controller turns the sink's per-lane adjust requests into drive bytes. It writes those bytes to the sink and reports the swing and pre-emphasis levels on its outputs, where the PHY picks them up. If either phase fails at 270000 kB/s, the controller retries at 162000 kB/s and chooses the lane count again. When the attempts end, it always restores the training-pattern field to "off" by a read-modify-write. It then pulses `done_o` and holds the result on `pass_o`. The real wait times (100 µs and 400 µs) are parameters in clock cycles.

Top module: `dp_link_trainer`

## Requirements
- R1: On `start_i` the ceiling rate code is the smaller of `sink_rate_i` and `enc_rate_i` (units of 27000 kB/s). Training starts at 270000 kB/s if that code is 10 or more, or at 162000 kB/s if it is 6 or more. Otherwise no link configuration is written, only the pattern-off sequence runs, and `pass_o` is 0.
- R2: The lane ceiling is the smaller of the clamped sink and encoder counts. The clamp maps 0 and 1 to 1, 2 and 3 to 2, and 4 or more to 4. `lane_cnt_o` is always 1, 2 or 4.
- R3: Before each attempt the lane count starts at the ceiling and is halved while (lanes/2) times the current rate exceeds `data_rate_i`. Then, at 270000 kB/s, the rate drops to 162000 kB/s if 162000 times the lane count still exceeds `data_rate_i`.
- R4: Each attempt begins with a 2-byte write to address 0x100. Byte 0 is the rate divided by 27000 (10 or 6). Byte 1 is the lane count, with bit 7 set when `sink_enh_i` is 1.
- R5: The training pattern is set by a 1-byte read of address 0x102, followed by a 1-byte write of the same value with bits 1:0 replaced. The sequence is 1 for clock recovery, 2 for equalisation and 0 at the end, and bits 7:2 are preserved.
- R6: Lane i's adjust nibble sits at bit 4*(i mod 2) of status byte 4+i/2, with swing in bits 1:0 and pre-emphasis in bits 3:2. Its drive byte is pre-emphasis<<3 | swing, plus bit 2 when swing is 3 and bit 5 when pre-emphasis is 3. Inactive lanes get 0. All four bytes go in one 4-byte write to 0x103. `swing_o`/`preemph_o` carry 2 bits per lane from the last committed bytes.
- R7: A clock-recovery iteration commits the drive bytes, waits `CR_WAIT_CYC` cycles and reads 6 status bytes from 0x202. The phase passes when bit 0 (clock-recovery done) of every active lane's status nibble (byte i/2, bit 4*(i mod 2)) is set.
- R8: Clock recovery aborts when the lowest active lane lacking clock-recovery done has the max-swing bit set in the drive byte committed in that iteration.
- R9: Clock recovery gives up after `CR_TRY_LIMIT` (5) status reads at the same lane-0 committed swing. A change of that swing restarts the count.
- R10: An equalisation iteration waits `EQ_WAIT_CYC`, reads the status and then commits the drive bytes. It passes when status byte 2 bit 0 (alignment) is set and every active lane has nibble bits 0, 1 and 2 set. At most `EQ_READ_LIMIT` (6) status reads are made.
- R11: Equalisation fails at once, after that iteration's commit, when any active lane lacks clock-recovery done.
- R12: A failed attempt at 270000 kB/s is retried at 162000 kB/s. A failure there ends training with `pass_o` = 0.
- R13: `done_o` is a one-cycle pulse at the end. `pass_o`, `rate_code_o` and `lane_cnt_o` hold until the next start. `aux_req_o` and its address stay stable until `aux_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a training run (taken when idle) |
| sink_rate_i | input | 8 | Sink maximum rate, units of 27000 kB/s |
| sink_lanes_i | input | 5 | Sink maximum lane count |
| sink_enh_i | input | 1 | Sink supports enhanced framing |
| enc_rate_i | input | 8 | Encoder maximum rate, units of 27000 kB/s |
| enc_lanes_i | input | 5 | Encoder maximum lane count |
| data_rate_i | input | 24 | Required data rate, kB/s |
| aux_req_o | output | 1 | AUX request pending |
| aux_write_o | output | 1 | 1 = write, 0 = read |
| aux_addr_o | output | 20 | Sink register address |
| aux_len_o | output | 3 | Byte count |
| aux_wdata_o | output | 32 | Write bytes, byte 0 in bits 7:0 |
| aux_ack_i | input | 1 | Request completed |
| aux_ok_i | input | 1 | Request succeeded |
| aux_rdata_i | input | 48 | Read bytes, byte 0 in bits 7:0 |
| busy_o | output | 1 | Training in progress |
| done_o | output | 1 | One-cycle end pulse |
| pass_o | output | 1 | Training succeeded |
| rate_code_o | output | 8 | Chosen rate code (10 or 6) |
| lane_cnt_o | output | 3 | Chosen lane count |
| swing_o | output | 8 | Swing level, 2 bits per lane |
| preemph_o | output | 8 | Pre-emphasis level, 2 bits per lane |

## Verification
The hardest situation to reach is the clock-recovery retry counter restarting when the sink moves the lane-0 swing. It only shows when the committed swing differs from the previous iteration's. The counter also interacts with the abort rule, which reacts to a swing of 3. The bench's sink model asks for swing 1 from its first status onward, so the second commit changes the swing and the total status-read count grows from 5 to 6. Separate runs with swing 3 (early abort, fallback to the lower rate) and swing 0 (plain limit) pin down the other two outcomes.

// File: rtl/lt_pkg.sv
// Shared constants, state types and helper functions for the link trainer.
// Assumes sink register addresses follow the standard sink register layout.
package lt_pkg;
    localparam logic [19:0] ADDR_LINK_CFG  = 20'h00100;
    localparam logic [19:0] ADDR_PATTERN   = 20'h00102;
    localparam logic [19:0] ADDR_LANE_DRV  = 20'h00103;
    localparam logic [19:0] ADDR_STATUS    = 20'h00202;

    localparam int          RATE_UNIT = 27000;
    localparam logic [23:0] RATE_HI   = 24'd270000;
    localparam logic [23:0] RATE_LO   = 24'd162000;
    localparam logic [7:0]  CODE_HI   = 8'(270000 / RATE_UNIT);
    localparam logic [7:0]  CODE_LO   = 8'(162000 / RATE_UNIT);
    localparam logic [1:0]  IDX_NONE  = 2'd2;

    typedef enum logic [3:0] {
        S_IDLE, S_SELECT, S_CFG_WR, S_PAT_RD, S_PAT_WR,
        S_COMMIT, S_WAIT, S_STAT_RD, S_EVAL, S_FINISH
    } state_t;

    typedef enum logic [1:0] {PH_CR, PH_EQ, PH_OFF} phase_t;

    // Clamp a reported lane count to a supported power of two.
    function automatic logic [2:0] clamp_lanes(input logic [4:0] n);
        if (n >= 5'd4)      return 3'd4;
        else if (n >= 5'd2) return 3'd2;
        else                return 3'd1;
    endfunction

    // Index of the first candidate rate not above the given ceiling code.
    function automatic logic [1:0] first_rate_idx(input logic [7:0] code);
        if (code >= CODE_HI)      return 2'd0;
        else if (code >= CODE_LO) return 2'd1;
        else                      return IDX_NONE;
    endfunction
endpackage

// File: rtl/lt_rate_pick.sv
// Combinational choice of lane count and rate for one attempt.
// Assumes idx_i is 0 (270000) or 1 (162000) and max_lanes_i is 1, 2 or 4.
module lt_rate_pick
    import lt_pkg::*;
(
    input  logic [1:0]  idx_i,
    input  logic [2:0]  max_lanes_i,
    input  logic [23:0] data_rate_i,
    output logic [1:0]  idx_o,
    output logic [2:0]  lanes_o,
    output logic [7:0]  code_o
);
    localparam int PW = 27;

    // Halve lanes while half still exceed the need, then try the lower rate.
    always_comb begin
        logic [23:0]   rate;
        logic [2:0]    nr;
        logic [PW-1:0] half_cap;
        logic [PW-1:0] lo_cap;
        rate = (idx_i == 2'd0) ? RATE_HI : RATE_LO;
        nr   = max_lanes_i;
        for (int k = 0; k < 2; k++) begin
            half_cap = PW'(nr >> 1) * PW'(rate);
            if (half_cap > PW'(data_rate_i)) nr = nr >> 1;
        end
        lo_cap = PW'(nr) * PW'(RATE_LO);
        idx_o  = idx_i;
        if (idx_i == 2'd0 && lo_cap > PW'(data_rate_i)) idx_o = 2'd1;
        lanes_o = nr;
        code_o  = (idx_o == 2'd0) ? CODE_HI : CODE_LO;
    end
endmodule

// File: rtl/lt_drive_map.sv
// Maps the sink's per-lane adjust nibbles to drive bytes with max flags.
// Assumes adj_i holds status bytes 4 and 5; lanes at or above lanes_i get 0.
module lt_drive_map #(
    parameter int LANES = 4
) (
    input  logic [4*LANES-1:0] adj_i,
    input  logic [2:0]         lanes_i,
    output logic [8*LANES-1:0] drive_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [1:0] sw;
        logic [1:0] pe;
        logic       act;
        assign sw  = adj_i[4*g +: 2];
        assign pe  = adj_i[4*g+2 +: 2];
        assign act = 32'(g) < 32'(lanes_i);
        // One drive byte: pre-emphasis at 4:3, swing at 1:0, max flags 5 and 2.
        assign drive_o[8*g +: 8] = act ? {2'b00, pe == 2'd3, pe, sw == 2'd3, sw} : 8'h00;
    end
endmodule

// File: rtl/lt_status_eval.sv
// Evaluates the sink status bytes 0..2 against the active lane count.
// Assumes lane i's nibble is at bit 4*i of the 24-bit status word.
module lt_status_eval #(
    parameter int LANES = 4
) (
    input  logic [23:0]      stat_i,
    input  logic [2:0]       lanes_i,
    input  logic [LANES-1:0] maxsw_i,
    output logic             cr_all_o,
    output logic             cr_abort_o,
    output logic             eq_all_o
);
    // Scan active lanes: all-CR, first-missing-CR abort, and full EQ check.
    always_comb begin
        logic found;
        logic [3:0] nib;
        cr_all_o   = 1'b1;
        cr_abort_o = 1'b0;
        eq_all_o   = stat_i[16];
        found      = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            nib = stat_i[4*i +: 4];
            if (i < 32'(lanes_i)) begin
                if (!nib[0]) begin
                    cr_all_o = 1'b0;
                    if (!found) cr_abort_o = maxsw_i[i];
                    found = 1'b1;
                end
                if (nib[2:0] != 3'b111) eq_all_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/dp_link_trainer.sv
// Link training sequencer: picks rate and lanes, programs the sink over an
// abstract AUX port, runs clock recovery then equalisation, falls back to the
// lower rate on failure and finally switches the training pattern off.
// Assumes one outstanding AUX request, completed by a one-cycle aux_ack_i.
module dp_link_trainer
    import lt_pkg::*;
#(
    parameter int CR_WAIT_CYC   = 20000,
    parameter int EQ_WAIT_CYC   = 80000,
    parameter int CR_TRY_LIMIT  = 5,
    parameter int EQ_READ_LIMIT = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [7:0]  sink_rate_i,
    input  logic [4:0]  sink_lanes_i,
    input  logic        sink_enh_i,
    input  logic [7:0]  enc_rate_i,
    input  logic [4:0]  enc_lanes_i,
    input  logic [23:0] data_rate_i,
    output logic        aux_req_o,
    output logic        aux_write_o,
    output logic [19:0] aux_addr_o,
    output logic [2:0]  aux_len_o,
    output logic [31:0] aux_wdata_o,
    input  logic        aux_ack_i,
    input  logic        aux_ok_i,
    input  logic [47:0] aux_rdata_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        pass_o,
    output logic [7:0]  rate_code_o,
    output logic [2:0]  lane_cnt_o,
    output logic [7:0]  swing_o,
    output logic [7:0]  preemph_o
);
    localparam int LANES  = 4;
    localparam int WMAX   = (CR_WAIT_CYC > EQ_WAIT_CYC) ? CR_WAIT_CYC : EQ_WAIT_CYC;
    localparam int TMW    = $clog2(WMAX + 1);
    localparam int LIMMAX = (CR_TRY_LIMIT > EQ_READ_LIMIT) ? CR_TRY_LIMIT : EQ_READ_LIMIT;
    localparam int TRW    = $clog2(LIMMAX + 1);

    state_t            state_q;
    phase_t            phase_q;
    logic [1:0]        idx_q;
    logic [2:0]        maxl_q, lanes_q;
    logic [7:0]        code_q, patb_q;
    logic [23:0]       stat_q;
    logic [15:0]       adj_q;
    logic [8*LANES-1:0] conf_q;
    logic [TRW-1:0]    tries_q;
    logic [1:0]        volt_q;
    logic              eq_ok_q, cr_ok_q, pass_q;
    logic [TMW-1:0]    timer_q;

    logic [1:0]        pick_idx;
    logic [2:0]        pick_lanes;
    logic [7:0]        pick_code;
    logic [8*LANES-1:0] conf_next;
    logic [LANES-1:0]  maxsw;
    logic              cr_all, cr_abort, eq_all;
    logic [1:0]        pat_val;
    logic [TRW-1:0]    cr_base, cr_next;
    logic [TMW-1:0]    wait_last;
    logic              unused_rd;

    assign unused_rd = &{1'b0, aux_rdata_i[31:24]};

    lt_rate_pick u_pick (
        .idx_i(idx_q), .max_lanes_i(maxl_q), .data_rate_i(data_rate_i),
        .idx_o(pick_idx), .lanes_o(pick_lanes), .code_o(pick_code)
    );

    lt_drive_map #(.LANES(LANES)) u_drive (
        .adj_i(adj_q), .lanes_i(lanes_q), .drive_o(conf_next)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign maxsw[g]          = conf_q[8*g+2];
        assign swing_o[2*g +: 2]   = conf_q[8*g +: 2];
        assign preemph_o[2*g +: 2] = conf_q[8*g+3 +: 2];
    end

    lt_status_eval #(.LANES(LANES)) u_eval (
        .stat_i(stat_q), .lanes_i(lanes_q), .maxsw_i(maxsw),
        .cr_all_o(cr_all), .cr_abort_o(cr_abort), .eq_all_o(eq_all)
    );

    // Pattern value per phase, CR try bookkeeping and wait length.
    always_comb begin
        unique case (phase_q)
            PH_CR:   pat_val = 2'd1;
            PH_EQ:   pat_val = 2'd2;
            default: pat_val = 2'd0;
        endcase
        cr_base   = (conf_q[1:0] != volt_q) ? '0 : tries_q;
        cr_next   = cr_base + 1'b1;
        wait_last = (phase_q == PH_CR) ? TMW'(CR_WAIT_CYC - 1) : TMW'(EQ_WAIT_CYC - 1);
    end

    // AUX request fields decoded from the current state.
    always_comb begin
        aux_req_o   = 1'b0;
        aux_write_o = 1'b0;
        aux_addr_o  = '0;
        aux_len_o   = '0;
        aux_wdata_o = '0;
        unique case (state_q)
            S_CFG_WR: begin
                aux_req_o = 1'b1; aux_write_o = 1'b1; aux_addr_o = ADDR_LINK_CFG; aux_len_o = 3'd2;
                aux_wdata_o = {16'h0, sink_enh_i, 4'h0, lanes_q, code_q};
            end
            S_PAT_RD: begin
                aux_req_o = 1'b1; aux_addr_o = ADDR_PATTERN; aux_len_o = 3'd1;
            end
            S_PAT_WR: begin
                aux_req_o = 1'b1; aux_write_o = 1'b1; aux_addr_o = ADDR_PATTERN; aux_len_o = 3'd1;
                aux_wdata_o = {24'h0, patb_q[7:2], pat_val};
            end
            S_COMMIT: begin
                aux_req_o = 1'b1; aux_write_o = 1'b1; aux_addr_o = ADDR_LANE_DRV; aux_len_o = 3'd4;
                aux_wdata_o = conf_next;
            end
            S_STAT_RD: begin
                aux_req_o = 1'b1; aux_addr_o = ADDR_STATUS; aux_len_o = 3'd6;
            end
            default: ;
        endcase
    end

    // Training sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;  phase_q <= PH_OFF;  idx_q <= IDX_NONE;
            maxl_q  <= 3'd1;    lanes_q <= 3'd1;    code_q <= '0;
            patb_q  <= '0;      stat_q  <= '0;      adj_q  <= '0;
            conf_q  <= '0;      tries_q <= '0;      volt_q <= '0;
            eq_ok_q <= 1'b0;    cr_ok_q <= 1'b0;    pass_q <= 1'b0;
            timer_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    pass_q  <= 1'b0;
                    idx_q   <= first_rate_idx((sink_rate_i < enc_rate_i) ? sink_rate_i : enc_rate_i);
                    maxl_q  <= (clamp_lanes(sink_lanes_i) < clamp_lanes(enc_lanes_i))
                               ? clamp_lanes(sink_lanes_i) : clamp_lanes(enc_lanes_i);
                    state_q <= S_SELECT;
                end
                S_SELECT: begin
                    if (idx_q == IDX_NONE) begin
                        phase_q <= PH_OFF;
                        state_q <= S_PAT_RD;
                    end else begin
                        idx_q   <= pick_idx;
                        lanes_q <= pick_lanes;
                        code_q  <= pick_code;
                        state_q <= S_CFG_WR;
                    end
                end
                S_CFG_WR: if (aux_ack_i) begin
                    phase_q <= PH_CR;  stat_q <= '0;  adj_q <= '0;
                    conf_q  <= '0;     tries_q <= '0; volt_q <= '0;
                    state_q <= S_PAT_RD;
                end
                S_PAT_RD: if (aux_ack_i) begin
                    patb_q  <= aux_rdata_i[7:0];
                    state_q <= S_PAT_WR;
                end
                S_PAT_WR: if (aux_ack_i) begin
                    unique case (phase_q)
                        PH_CR:   state_q <= S_COMMIT;
                        PH_EQ:   state_q <= S_WAIT;
                        default: state_q <= S_FINISH;
                    endcase
                end
                S_COMMIT: if (aux_ack_i) begin
                    conf_q <= conf_next;
                    if (!aux_ok_i) begin
                        idx_q <= idx_q + 1'b1; state_q <= S_SELECT;
                    end else if (phase_q == PH_CR) begin
                        state_q <= S_WAIT;
                    end else if (eq_ok_q) begin
                        pass_q <= 1'b1; phase_q <= PH_OFF; state_q <= S_PAT_RD;
                    end else if (!cr_ok_q || 32'(tries_q) + 1 >= EQ_READ_LIMIT) begin
                        idx_q <= idx_q + 1'b1; state_q <= S_SELECT;
                    end else begin
                        tries_q <= tries_q + 1'b1; state_q <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (timer_q == wait_last) begin
                        timer_q <= '0; state_q <= S_STAT_RD;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                S_STAT_RD: if (aux_ack_i) begin
                    if (aux_ok_i) begin
                        stat_q  <= aux_rdata_i[23:0];
                        adj_q   <= aux_rdata_i[47:32];
                        state_q <= S_EVAL;
                    end else begin
                        idx_q <= idx_q + 1'b1; state_q <= S_SELECT;
                    end
                end
                S_EVAL: begin
                    if (phase_q == PH_EQ) begin
                        eq_ok_q <= eq_all; cr_ok_q <= cr_all; state_q <= S_COMMIT;
                    end else begin
                        volt_q <= conf_q[1:0];
                        if (cr_all) begin
                            phase_q <= PH_EQ; tries_q <= '0; state_q <= S_PAT_RD;
                        end else if (cr_abort || 32'(cr_next) >= CR_TRY_LIMIT) begin
                            idx_q <= idx_q + 1'b1; state_q <= S_SELECT;
                        end else begin
                            tries_q <= cr_next; state_q <= S_COMMIT;
                        end
                    end
                end
                S_FINISH: state_q <= S_IDLE;
                default:  state_q <= S_IDLE;
            endcase
        end
    end

    assign busy_o      = state_q != S_IDLE;
    assign done_o      = state_q == S_FINISH;
    assign pass_o      = pass_q;
    assign rate_code_o = code_q;
    assign lane_cnt_o  = lanes_q;

    // R13
    aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_req_o && !aux_ack_i |=> aux_req_o && $stable(aux_addr_o) && $stable(aux_write_o));
    // R2
    lane_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lane_cnt_o) == 1 && lane_cnt_o != 3'd0);
    // R9
    cr_try_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_CR |-> 32'(tries_q) < CR_TRY_LIMIT);
    // R10
    eq_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_EQ |-> 32'(tries_q) < EQ_READ_LIMIT);
    // R4
    cfg_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_req_o && aux_write_o && aux_addr_o == ADDR_LINK_CFG
        |-> aux_wdata_o[7:0] == CODE_HI || aux_wdata_o[7:0] == CODE_LO);
endmodule

// File: tb/dp_link_trainer_bench.sv
module dp_link_trainer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  sink_rate_i = '0;
    logic [4:0]  sink_lanes_i = '0;
    logic        sink_enh_i = 1'b0;
    logic [7:0]  enc_rate_i = '0;
    logic [4:0]  enc_lanes_i = '0;
    logic [23:0] data_rate_i = '0;
    logic        aux_req_o, aux_write_o;
    logic [19:0] aux_addr_o;
    logic [2:0]  aux_len_o;
    logic [31:0] aux_wdata_o;
    logic        aux_ack_i = 1'b0;
    logic        aux_ok_i = 1'b1;
    logic [47:0] aux_rdata_i = '0;
    logic        busy_o, done_o, pass_o;
    logic [7:0]  rate_code_o;
    logic [2:0]  lane_cnt_o;
    logic [7:0]  swing_o, preemph_o;

    always #2.5 clk = ~clk;

    dp_link_trainer #(.CR_WAIT_CYC(4), .EQ_WAIT_CYC(8)) u_dp_link_trainer (.*);

    int checks = 0;
    int errors = 0;
    int scn = 0;
    int n_stat, n_cfg, n_pat, n_lane;
    logic [15:0] first_cfg, last_cfg;
    logic [31:0] last_lane;
    logic [7:0]  patreg;
    logic [7:0]  pat_log [8];
    logic [47:0] rd;

    localparam int SC_GOOD = 0, SC_DRIVE = 1, SC_ABORT = 2, SC_STUCK = 3,
                   SC_SWCHG = 4, SC_EQFAIL = 5, SC_CRLOSS = 6;

    function automatic logic [47:0] status_of(int s, logic [1:0] pat);
        logic [47:0] good = {8'h00, 8'h00, 8'h00, 8'h01, 8'h77, 8'h77};
        case (s)
            SC_DRIVE:  return {8'h00, 8'h2D, 8'h00, 8'h01, 8'h77, 8'h77};
            SC_ABORT:  return {8'h33, 8'h33, 24'h0, 8'h00};
            SC_STUCK:  return 48'h0;
            SC_SWCHG:  return {8'h00, 8'h11, 32'h0};
            SC_EQFAIL: return (pat == 2'd2) ? {16'h0, 8'h00, 8'h00, 8'h11, 8'h11} : good;
            SC_CRLOSS: return (pat == 2'd2) ? 48'h0 : good;
            default:   return good;
        endcase
    endfunction

    // Sink model on the AUX port: records writes, answers two cycles later.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && aux_req_o) begin
                rd = '0;
                if (aux_write_o) begin
                    if (aux_addr_o == 20'h00100) begin
                        n_cfg++;
                        if (n_cfg == 1) first_cfg = aux_wdata_o[15:0];
                        last_cfg = aux_wdata_o[15:0];
                    end else if (aux_addr_o == 20'h00102) begin
                        if (n_pat < 8) pat_log[n_pat] = aux_wdata_o[7:0];
                        n_pat++;
                        patreg = aux_wdata_o[7:0];
                    end else if (aux_addr_o == 20'h00103) begin
                        n_lane++;
                        last_lane = aux_wdata_o;
                    end
                end else if (aux_addr_o == 20'h00102) begin
                    rd = {40'h0, patreg};
                end else if (aux_addr_o == 20'h00202) begin
                    n_stat++;
                    rd = status_of(scn, patreg[1:0]);
                end
                repeat (2) @(negedge clk);
                aux_rdata_i = rd;
                aux_ack_i   = 1'b1;
                @(negedge clk);
                aux_ack_i   = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input int s, input logic [7:0] sr, input logic [4:0] sl, input logic se,
                       input logic [7:0] er, input logic [4:0] el, input logic [23:0] dr);
        int cyc = 0;
        scn = s; n_stat = 0; n_cfg = 0; n_pat = 0; n_lane = 0;
        first_cfg = '0; last_cfg = '0; last_lane = '0; patreg = 8'hA0;
        sink_rate_i = sr; sink_lanes_i = sl; sink_enh_i = se;
        enc_rate_i = er; enc_lanes_i = el; data_rate_i = dr;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        while (!done_o && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done_o, "R13", "done reached", int'(done_o), 1);
    endtask

    task automatic t_reset();
        chk(!busy_o && !done_o && !aux_req_o && !pass_o, "R13", "reset idle",
            {busy_o, done_o, aux_req_o, pass_o}, 0);
    endtask

    task automatic t_select_basic();
        run(SC_GOOD, 8'd10, 5'd4, 1'b1, 8'd10, 5'd4, 24'd300000);
        chk(rate_code_o == 8'd6 && lane_cnt_o == 3'd2, "R3", "rate/lanes",
            {rate_code_o, 5'b0, lane_cnt_o}, 16'h0602);
        chk(first_cfg == 16'h8206, "R4", "link cfg bytes", first_cfg, 16'h8206);
        chk(n_pat == 3 && pat_log[0] == 8'hA1 && pat_log[1] == 8'hA2 && pat_log[2] == 8'hA0,
            "R5", "pattern sequence", {pat_log[0], pat_log[1], pat_log[2]}, 24'hA1A2A0);
        chk(pass_o && n_stat == 2, "R7", "pass after one CR and one EQ read", n_stat, 2);
        @(negedge clk);
        chk(!done_o && pass_o && rate_code_o == 8'd6, "R13", "done pulse, result held",
            {done_o, pass_o}, 1);
    endtask

    task automatic t_clamp();
        run(SC_GOOD, 8'd10, 5'd3, 1'b0, 8'd10, 5'd4, 24'd1000000);
        chk(lane_cnt_o == 3'd2 && rate_code_o == 8'd10, "R2", "sink 3 lanes clamp",
            lane_cnt_o, 2);
        chk(first_cfg == 16'h020A, "R4", "cfg without enhanced", first_cfg, 16'h020A);
        run(SC_GOOD, 8'd10, 5'd7, 1'b0, 8'd10, 5'd4, 24'd1000000);
        chk(lane_cnt_o == 3'd4 && rate_code_o == 8'd10, "R2", "sink 7 lanes clamp",
            lane_cnt_o, 4);
        run(SC_GOOD, 8'd10, 5'd0, 1'b0, 8'd10, 5'd4, 24'd100000);
        chk(lane_cnt_o == 3'd1 && rate_code_o == 8'd6, "R2", "zero lanes clamp",
            {rate_code_o, 5'b0, lane_cnt_o}, 16'h0601);
        run(SC_GOOD, 8'd10, 5'd4, 1'b0, 8'd10, 5'd4, 24'd0);
        chk(lane_cnt_o == 3'd1 && rate_code_o == 8'd6, "R3", "zero data rate",
            {rate_code_o, 5'b0, lane_cnt_o}, 16'h0601);
    endtask

    task automatic t_rate_ceiling();
        run(SC_GOOD, 8'd10, 5'd1, 1'b0, 8'd6, 5'd1, 24'd100000);
        chk(first_cfg[7:0] == 8'd6 && n_cfg == 1, "R1", "encoder caps rate", first_cfg, 16'h0106);
        run(SC_GOOD, 8'd5, 5'd4, 1'b0, 8'd10, 5'd4, 24'd100000);
        chk(n_cfg == 0 && !pass_o && n_pat == 1 && pat_log[0] == 8'hA0, "R1",
            "no candidate rate", n_cfg, 0);
    endtask

    task automatic t_drive();
        run(SC_DRIVE, 8'd10, 5'd2, 1'b0, 8'd10, 5'd2, 24'd500000);
        chk(last_lane == 32'h0000_0239, "R6", "drive bytes", last_lane, 32'h0239);
        chk(swing_o == 8'h09 && preemph_o == 8'h03, "R6", "level outputs",
            {swing_o, preemph_o}, 16'h0903);
        chk(pass_o && n_lane == 2, "R10", "EQ commit after read", n_lane, 2);
    endtask

    task automatic t_abort();
        run(SC_ABORT, 8'd10, 5'd1, 1'b0, 8'd10, 5'd1, 24'd200000);
        chk(n_stat == 4 && !pass_o, "R8", "abort at max swing", n_stat, 4);
        chk(n_cfg == 2 && last_cfg[7:0] == 8'd6, "R12", "fallback to lower rate", last_cfg, 16'h0106);
        chk(last_lane[7:0] == 8'h07, "R6", "max swing flag", last_lane[7:0], 8'h07);
    endtask

    task automatic t_cr_limit();
        run(SC_STUCK, 8'd10, 5'd1, 1'b0, 8'd6, 5'd1, 24'd100000);
        chk(n_stat == 5 && !pass_o, "R9", "constant swing limit", n_stat, 5);
        run(SC_SWCHG, 8'd10, 5'd1, 1'b0, 8'd6, 5'd1, 24'd100000);
        chk(n_stat == 6 && !pass_o, "R9", "swing change restarts count", n_stat, 6);
    endtask

    task automatic t_eq();
        run(SC_EQFAIL, 8'd10, 5'd1, 1'b0, 8'd6, 5'd1, 24'd100000);
        chk(n_stat == 7 && n_lane == 7 && !pass_o, "R10", "EQ read limit", n_stat, 7);
        run(SC_CRLOSS, 8'd10, 5'd1, 1'b0, 8'd6, 5'd1, 24'd100000);
        chk(n_stat == 2 && n_lane == 2 && !pass_o, "R11", "EQ exit on CR loss", n_stat, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_select_basic();
        t_clamp();
        t_rate_ceiling();
        t_drive();
        t_abort();
        t_cr_limit();
        t_eq();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule